// File: doc/BRIEF.md
# Linked Context Save/Restore Engine

This block is the sequencer behind subroutine call and return. It saves the upper half of the processor context into memory and brings it back. Memory holds a pool of 64-byte frames, and each free frame points to the next free one through its first word. On a call, the engine takes the frame named by the free pointer and reads that frame's link word to learn the next free frame. It then overwrites the frame with sixteen words of state and chains the frame onto the list of saved contexts. The free pointer moves on to the next free frame.

On a return, the engine follows the previous-context link to the newest saved frame. It reloads the sixteen words and writes the current free pointer into the frame's first word, which puts the frame back at the head of the free pool. The link moves back to the context that was saved before. Because the same first word serves as the free-list link and as the saved chain link, no separate allocator is needed.

The engine makes one memory access per cycle through a single-port word interface with one cycle of read latency. It reads and writes the register file by frame-slot index. It reports its new link, status and free pointer values as a single update pulse. When a precondition fails, it reports a trap code and changes no register and no memory.

Top module: `ctx_link_engine`

## Requirements
- R1: A 20-bit frame pointer p maps to byte address {p[19:16], 6'b0, p[15:0], w[3:0], 2'b00}, where w is the word number in the frame (0..15).
- R2: A call first reads word 0 of the frame at the free pointer. In the next sixteen cycles it writes words 0..15 in order: word 0 = old link, word 1 = old status, and words 2..15 = register-file slots 2..15 (slot 2 = A10, slot 3 = A11, 4..7 = D8..D11, 8..11 = A12..A15, 12..15 = D12..D15).
- R3: After a call, the link equals {priority[7:0], interrupt-enable, 1'b1, old link[21:20], old free[19:0]}. The free pointer equals {old free[31:12+8], next[19:0]}, where next is the word-0 value read from memory. Link bit 23 is the saved interrupt enable and bit 22 is the upper-context flag.
- R4: A call writes the requested next PC into register slot 3 (A11) and sets status bit 7 (call-depth enable). All other status bits stay as they were.
- R5: A call traps with code 1 when free[19:0] is zero. It traps with code 2 when free[19:0] equals limit[19:0]. Code 1 takes priority.
- R6: A return traps with code 3 when link[19:0] is zero. It traps with code 4 when link bit 22 is clear. Code 3 takes priority.
- R7: A return sets PC to the pre-return A11 with bit 0 cleared. It reads words 0..15 of the frame at link[19:0] in order and restores register slots 2..15 from words 2..15. It then writes the current free pointer into word 0. The new link is the loaded word 0, and the free pointer becomes {free[31:20], old link[19:0]}.
- R8: With the full-restore mode input high, a return loads status from word 1 as a whole. With the input low, status bits 25:24 keep their current value and all other bits come from word 1.
- R9: Busy is high for exactly 18 cycles per call or return, counted from the cycle after the request. The memory interface is idle whenever busy is low, and requests that arrive while busy are ignored.
- R10: A trapping request makes no memory access and no register or control update. It raises trap-valid for one cycle in the cycle after the request, with the code on trap_code.
- R11: After reset, busy, trap-valid, the memory enable and all update strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a call or return |
| req_ret | input | 1 | 1 = return, 0 = call |
| req_next_pc | input | 32 | Return address stored by a call |
| full_stat_restore | input | 1 | Return restores the whole status word |
| busy | output | 1 | Sequence in progress |
| link_in | input | 32 | Current previous-context link |
| stat_in | input | 32 | Current status word |
| free_in | input | 32 | Current free-frame pointer |
| limit_in | input | 32 | Free-list limit pointer |
| prio_in | input | 8 | Current priority number |
| ie_in | input | 1 | Current interrupt enable |
| ctl_we | output | 1 | Update strobe for link, status and free pointer |
| link_out | output | 32 | New link value |
| stat_out | output | 32 | New status value |
| free_out | output | 32 | New free pointer value |
| pc_we | output | 1 | PC update strobe (return) |
| pc_out | output | 32 | New PC |
| rf_ridx | output | 4 | Register-file read slot |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_widx | output | 4 | Register-file write slot |
| rf_wdata | output | 32 | Register-file write data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |
| trap_valid | output | 1 | Trap pulse |
| trap_code | output | 3 | Trap code (1..4) |

## Verification
The bench follows a call with a return on the same frame. A design that got the frame stores or loads wrong, or mixed up register slots, would fail to restore the registers. One that swapped the wrong word 0 would corrupt the free pointer or the link chain. Return is run in both status modes with different current bits 25:24, which catches a merge that keeps or drops the wrong field. A request injected mid-sequence would lengthen the access log if it were not ignored. Each trap cause is forced, including zero and limit both at once to test priority, and the bench checks that no access and no register update occur.

// File: rtl/ctx_pkg.sv
// Package: shared constants and enumerations for the context save/restore engine.
// Assumes a 32-bit word machine with 16-word context frames.
package ctx_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned PTR_W       = 20;
    localparam int unsigned FRAME_WORDS = 16;
    localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);
    localparam int unsigned SEG_W       = 4;
    localparam int unsigned OFS_W       = PTR_W - SEG_W;
    localparam int unsigned PRIO_W      = 8;
    localparam int unsigned CODE_W      = 3;

    // Field positions that neighbouring logic decodes
    localparam int unsigned LINK_PIE_BIT   = 23;
    localparam int unsigned LINK_UPPER_BIT = 22;
    localparam int unsigned STAT_CDE_BIT   = 7;
    localparam int unsigned STAT_KEEP_LSB  = 24;
    localparam int unsigned STAT_KEEP_MSB  = 25;

    // Frame slot numbers
    localparam logic [IDX_W-1:0] SLOT_LINK = IDX_W'(0);
    localparam logic [IDX_W-1:0] SLOT_STAT = IDX_W'(1);
    localparam logic [IDX_W-1:0] SLOT_FIRST_REG = IDX_W'(2);
    localparam logic [IDX_W-1:0] SLOT_RET  = IDX_W'(3);
    localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(FRAME_WORDS - 1);

    typedef enum logic [CODE_W-1:0] {
        TRAP_NONE        = 3'd0,
        TRAP_FREE_EMPTY  = 3'd1,
        TRAP_FREE_LIMIT  = 3'd2,
        TRAP_CHAIN_EMPTY = 3'd3,
        TRAP_WRONG_KIND  = 3'd4
    } trap_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALL_FETCH,
        ST_CALL_STORE,
        ST_RET_LOAD,
        ST_RET_FREE,
        ST_DONE
    } state_e;
endpackage

// File: rtl/ctx_frame_addr.sv
// Module: ctx_frame_addr
// Forms the byte address of one word in a context frame from a frame pointer.
// Assumes frames are 64-byte aligned inside a segment chosen by the pointer's top bits.
module ctx_frame_addr
    import ctx_pkg::*;
(
    input  logic [PTR_W-1:0]  ptr,
    input  logic [IDX_W-1:0]  word,
    output logic [WORD_W-1:0] addr
);
    localparam int unsigned GAP_W = WORD_W - SEG_W - OFS_W - IDX_W - 2;

    // Segment bits on top, offset above the word number, zero padding elsewhere
    always_comb begin
        addr = {ptr[PTR_W-1:OFS_W], {GAP_W{1'b0}}, ptr[OFS_W-1:0], word, 2'b00};
    end
endmodule

// File: rtl/ctx_trap_check.sv
// Module: ctx_trap_check
// Decides whether a requested call or return may proceed and which trap it raises.
// Assumes inputs are the control register values present at request time.
module ctx_trap_check
    import ctx_pkg::*;
(
    input  logic              is_ret,
    input  logic [WORD_W-1:0] free_ptr,
    input  logic [WORD_W-1:0] limit_ptr,
    input  logic [WORD_W-1:0] link,
    output trap_e             code
);
    // Prioritised precondition checks for each direction
    always_comb begin
        code = TRAP_NONE;
        if (!is_ret) begin
            if (free_ptr[PTR_W-1:0] == '0) begin
                code = TRAP_FREE_EMPTY;
            end else if (free_ptr[PTR_W-1:0] == limit_ptr[PTR_W-1:0]) begin
                code = TRAP_FREE_LIMIT;
            end
        end else begin
            if (link[PTR_W-1:0] == '0) begin
                code = TRAP_CHAIN_EMPTY;
            end else if (!link[LINK_UPPER_BIT]) begin
                code = TRAP_WRONG_KIND;
            end
        end
    end
endmodule

// File: rtl/ctx_state_compose.sv
// Module: ctx_state_compose
// Builds the new link, status and free-pointer values at the end of a sequence.
// Assumes all inputs are the values captured at the request or loaded from memory.
module ctx_state_compose
    import ctx_pkg::*;
(
    input  logic              is_ret,
    input  logic              full_restore,
    input  logic [WORD_W-1:0] link_old,
    input  logic [WORD_W-1:0] stat_old,
    input  logic [WORD_W-1:0] free_old,
    input  logic [WORD_W-1:0] word0_seen,
    input  logic [WORD_W-1:0] stat_loaded,
    input  logic [PRIO_W-1:0] prio,
    input  logic              ie,
    output logic [WORD_W-1:0] link_new,
    output logic [WORD_W-1:0] stat_new,
    output logic [WORD_W-1:0] free_new
);
    localparam int unsigned MID_W = LINK_UPPER_BIT - PTR_W;

    logic [WORD_W-1:0] call_link, call_stat, ret_stat;

    // Call: chain the taken frame behind the current priority and enable
    always_comb begin
        call_link = {prio, ie, 1'b1, link_old[LINK_UPPER_BIT-1 -: MID_W], free_old[PTR_W-1:0]};
        call_stat = stat_old;
        call_stat[STAT_CDE_BIT] = 1'b1;
    end

    // Return: optionally keep the current protected status field
    always_comb begin
        ret_stat = stat_loaded;
        if (!full_restore) begin
            ret_stat[STAT_KEEP_MSB:STAT_KEEP_LSB] = stat_old[STAT_KEEP_MSB:STAT_KEEP_LSB];
        end
    end

    // Select per direction; the free pointer keeps its upper bits either way
    always_comb begin
        if (is_ret) begin
            link_new = word0_seen;
            stat_new = ret_stat;
            free_new = {free_old[WORD_W-1:PTR_W], link_old[PTR_W-1:0]};
        end else begin
            link_new = call_link;
            stat_new = call_stat;
            free_new = {free_old[WORD_W-1:PTR_W], word0_seen[PTR_W-1:0]};
        end
    end
endmodule

// File: rtl/ctx_link_engine.sv
// Module: ctx_link_engine (top)
// Sequences upper-context save on call and restore on return through a
// self-linking list of 16-word frames in memory.
// Assumes a single-port memory with one cycle of read latency, a register file
// with combinational read, and control registers that apply the update pulse.
module ctx_link_engine
    import ctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ret,
    input  logic [31:0]       req_next_pc,
    input  logic              full_stat_restore,
    output logic              busy,
    input  logic [31:0]       link_in,
    input  logic [31:0]       stat_in,
    input  logic [31:0]       free_in,
    input  logic [31:0]       limit_in,
    input  logic [7:0]        prio_in,
    input  logic              ie_in,
    output logic              ctl_we,
    output logic [31:0]       link_out,
    output logic [31:0]       stat_out,
    output logic [31:0]       free_out,
    output logic              pc_we,
    output logic [31:0]       pc_out,
    output logic [3:0]        rf_ridx,
    input  logic [31:0]       rf_rdata,
    output logic              rf_we,
    output logic [3:0]        rf_widx,
    output logic [31:0]       rf_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              trap_valid,
    output logic [2:0]        trap_code
);
    state_e            state;
    logic [IDX_W-1:0]  cnt;
    logic              is_ret_q, full_q, ie_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [WORD_W-1:0] link_q, stat_q, free_q, pc_q, word0_q, ldstat_q;
    logic [PRIO_W-1:0] prio_q;
    logic              trap_valid_q;
    trap_e             trap_q, trap_now;
    logic [IDX_W-1:0]  word_sel;

    ctx_trap_check u_trap (
        .is_ret    (req_ret),
        .free_ptr  (free_in),
        .limit_ptr (limit_in),
        .link      (link_in),
        .code      (trap_now)
    );

    ctx_frame_addr u_addr (
        .ptr  (ptr_q),
        .word (word_sel),
        .addr (mem_addr)
    );

    ctx_state_compose u_comp (
        .is_ret       (is_ret_q),
        .full_restore (full_q),
        .link_old     (link_q),
        .stat_old     (stat_q),
        .free_old     (free_q),
        .word0_seen   (word0_q),
        .stat_loaded  (ldstat_q),
        .prio         (prio_q),
        .ie           (ie_q),
        .link_new     (link_out),
        .stat_new     (stat_out),
        .free_new     (free_out)
    );

    // Sequencer state, request capture and word-0/status capture from memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            is_ret_q     <= 1'b0;
            full_q       <= 1'b0;
            ie_q         <= 1'b0;
            ptr_q        <= '0;
            link_q       <= '0;
            stat_q       <= '0;
            free_q       <= '0;
            pc_q         <= '0;
            word0_q      <= '0;
            ldstat_q     <= '0;
            prio_q       <= '0;
            trap_valid_q <= 1'b0;
            trap_q       <= TRAP_NONE;
        end else begin
            trap_valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (trap_now != TRAP_NONE) begin
                            trap_valid_q <= 1'b1;
                            trap_q       <= trap_now;
                        end else begin
                            is_ret_q <= req_ret;
                            ptr_q    <= req_ret ? link_in[PTR_W-1:0] : free_in[PTR_W-1:0];
                            link_q   <= link_in;
                            stat_q   <= stat_in;
                            free_q   <= free_in;
                            prio_q   <= prio_in;
                            ie_q     <= ie_in;
                            full_q   <= full_stat_restore;
                            pc_q     <= req_ret ? rf_rdata : req_next_pc;
                            cnt      <= '0;
                            state    <= req_ret ? ST_RET_LOAD : ST_CALL_FETCH;
                        end
                    end
                end
                ST_CALL_FETCH: begin
                    cnt   <= '0;
                    state <= ST_CALL_STORE;
                end
                ST_CALL_STORE: begin
                    if (cnt == SLOT_LINK) word0_q <= mem_rdata;
                    if (cnt == SLOT_LAST) state <= ST_DONE;
                    else                  cnt   <= cnt + 1'b1;
                end
                ST_RET_LOAD: begin
                    if (cnt == SLOT_STAT)      word0_q  <= mem_rdata;
                    if (cnt == SLOT_FIRST_REG) ldstat_q <= mem_rdata;
                    if (cnt == SLOT_LAST) state <= ST_RET_FREE;
                    else                  cnt   <= cnt + 1'b1;
                end
                ST_RET_FREE: state <= ST_DONE;
                ST_DONE:     state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    // Per-state drive of memory, register file and update strobes
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        word_sel  = '0;
        rf_ridx   = SLOT_RET;
        rf_we     = 1'b0;
        rf_widx   = '0;
        rf_wdata  = '0;
        ctl_we    = 1'b0;
        pc_we     = 1'b0;
        case (state)
            ST_CALL_FETCH: begin
                mem_en = 1'b1;
            end
            ST_CALL_STORE: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                word_sel = cnt;
                rf_ridx  = cnt;
                if (cnt == SLOT_LINK)      mem_wdata = link_q;
                else if (cnt == SLOT_STAT) mem_wdata = stat_q;
                else                       mem_wdata = rf_rdata;
            end
            ST_RET_LOAD: begin
                mem_en   = 1'b1;
                word_sel = cnt;
                if (cnt > SLOT_FIRST_REG) begin
                    rf_we    = 1'b1;
                    rf_widx  = cnt - 1'b1;
                    rf_wdata = mem_rdata;
                end
            end
            ST_RET_FREE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = free_q;
                rf_we     = 1'b1;
                rf_widx   = SLOT_LAST;
                rf_wdata  = mem_rdata;
            end
            ST_DONE: begin
                ctl_we = 1'b1;
                if (is_ret_q) begin
                    pc_we = 1'b1;
                end else begin
                    rf_we    = 1'b1;
                    rf_widx  = SLOT_RET;
                    rf_wdata = pc_q;
                end
            end
            default: ;
        endcase
    end

    // Output register views
    always_comb begin
        busy       = (state != ST_IDLE);
        pc_out     = {pc_q[WORD_W-1:1], 1'b0};
        trap_valid = trap_valid_q;
        trap_code  = trap_q;
    end

    // Memory stays idle outside a sequence
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    // A trap pulse comes with no sequence and no access
    p_trap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (!busy && !mem_en && !ctl_we));

    // The update pulse is the final busy cycle
    p_done_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> !busy);

    // A call's first access reads word 0, then writes that same word
    p_fetch_then_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && !is_ret_q) |-> (mem_en && !mem_we) ##1 (mem_we && mem_addr == $past(mem_addr)));

    // Padding bits of every frame address are zero
    p_addr_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr[1:0] == 2'b00 && mem_addr[27:22] == 6'd0));
endmodule

// File: tb/tb_ctx_link_engine.sv
module tb_ctx_link_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ret = 1'b0, full_stat_restore = 1'b0;
    logic [31:0] req_next_pc = '0;
    logic        busy;
    logic [31:0] link_r, stat_r, free_r, limit_r, pc_r;
    logic [7:0]  prio_r;
    logic        ie_r;
    logic        ctl_we, pc_we, rf_we, mem_en, mem_we, trap_valid;
    logic [31:0] link_out, stat_out, free_out, pc_out, rf_rdata, rf_wdata;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  rf_ridx, rf_widx;
    logic [2:0]  trap_code;
    logic [31:0] rf [16];
    logic [31:0] mem [4096];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int log_n = 0, ctl_cnt = 0, trap_cnt = 0, busy_cyc = 0;
    logic [31:0] log_addr [40];
    logic [31:0] log_data [40];
    logic        log_we   [40];
    logic [2:0]  last_code;
    logic [31:0] saved [16];

    always #10 clk = ~clk;

    ctx_link_engine dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ret(req_ret),
        .req_next_pc(req_next_pc), .full_stat_restore(full_stat_restore), .busy(busy),
        .link_in(link_r), .stat_in(stat_r), .free_in(free_r), .limit_in(limit_r),
        .prio_in(prio_r), .ie_in(ie_r), .ctl_we(ctl_we), .link_out(link_out),
        .stat_out(stat_out), .free_out(free_out), .pc_we(pc_we), .pc_out(pc_out),
        .rf_ridx(rf_ridx), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_widx(rf_widx),
        .rf_wdata(rf_wdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .trap_valid(trap_valid),
        .trap_code(trap_code)
    );

    assign rf_rdata = rf[rf_ridx];

    // Environment models: memory, register file, control registers
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[13:2]];
        end
        if (rf_we) rf[rf_widx] <= rf_wdata;
        if (ctl_we) begin
            link_r <= link_out;
            stat_r <= stat_out;
            free_r <= free_out;
        end
        if (pc_we) pc_r <= pc_out;
    end

    // Monitor between edges
    always @(negedge clk) begin
        if (mem_en && log_n < 40) begin
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_wdata;
            log_we[log_n]   = mem_we;
            log_n++;
        end
        if (ctl_we) ctl_cnt++;
        if (trap_valid) begin
            trap_cnt++;
            last_code = trap_code;
        end
        if (busy) busy_cyc++;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        log_n = 0; ctl_cnt = 0; trap_cnt = 0; busy_cyc = 0; last_code = 3'd0;
    endtask

    // Issue one request; optionally poke a second request while busy
    task automatic do_req(input logic ret, input logic poke);
        int guard;
        clear_mon();
        @(posedge clk); #5;
        req_valid = 1'b1; req_ret = ret;
        @(posedge clk); #5;
        req_valid = 1'b0;
        guard = 0;
        while (busy && guard < 100) begin
            guard++;
            if (poke && guard == 4) begin req_valid = 1'b1; req_ret = !ret; end
            else req_valid = 1'b0;
            @(posedge clk); #5;
        end
        req_valid = 1'b0;
        if (guard >= 100) chk("R9 busy stuck", 32'(guard), 32'd0);
        @(posedge clk); #5;
    endtask

    task automatic t_reset();
        chk("R11 busy", {31'd0, busy}, 32'd0);
        chk("R11 trap_valid", {31'd0, trap_valid}, 32'd0);
        chk("R11 mem_en", {31'd0, mem_en}, 32'd0);
        chk("R11 strobes", {29'd0, ctl_we, pc_we, rf_we}, 32'd0);
    endtask

    task automatic t_call_first();
        for (int i = 2; i < 16; i++) rf[i] <= 32'hA000_0000 + 32'(i) * 32'h111;
        link_r <= 32'h00F0_0000; stat_r <= 32'h0300_0001; free_r <= 32'hABC3_0005;
        limit_r <= 32'h0000_0077; prio_r <= 8'h5A; ie_r <= 1'b1;
        mem[12'h050] <= 32'h0000_0009;
        req_next_pc = 32'h8000_1235;
        @(posedge clk); #5;
        for (int i = 0; i < 16; i++) saved[i] = rf[i];
        do_req(1'b0, 1'b1);
        chk("R9 call access count", 32'(log_n), 32'd17);
        chk("R9 call busy cycles", 32'(busy_cyc), 32'd18);
        chk("R1 call fetch addr", log_addr[0], 32'h3000_0140);
        chk("R2 first access is read", {31'd0, log_we[0]}, 32'd0);
        for (int k = 0; k < 16; k++) begin
            chk("R2 store addr", log_addr[k+1], 32'h3000_0140 + 32'(k) * 4);
            chk("R2 store we", {31'd0, log_we[k+1]}, 32'd1);
        end
        chk("R2 word0 old link", log_data[1], 32'h00F0_0000);
        chk("R2 word1 old status", log_data[2], 32'h0300_0001);
        for (int k = 2; k < 16; k++) chk("R2 reg word", log_data[k+1], saved[k]);
        chk("R3 link after call", link_r, 32'h5AF3_0005);
        chk("R3 free after call", free_r, 32'hABC0_0009);
        chk("R4 status bit7", stat_r, 32'h0300_0081);
        chk("R4 A11 next pc", rf[3], 32'h8000_1235);
        chk("R9 one update", 32'(ctl_cnt), 32'd1);
    endtask

    task automatic t_ret_merge();
        for (int i = 2; i < 16; i++) if (i != 3) rf[i] <= 32'hDEAD_0000 + 32'(i);
        stat_r <= 32'h0200_00FF;
        full_stat_restore = 1'b0;
        @(posedge clk); #5;
        do_req(1'b1, 1'b0);
        chk("R9 ret access count", 32'(log_n), 32'd17);
        chk("R9 ret busy cycles", 32'(busy_cyc), 32'd18);
        for (int k = 0; k < 16; k++) begin
            chk("R7 load addr", log_addr[k], 32'h3000_0140 + 32'(k) * 4);
            chk("R7 load is read", {31'd0, log_we[k]}, 32'd0);
        end
        chk("R7 free write addr", log_addr[16], 32'h3000_0140);
        chk("R7 free write data", log_data[16], 32'hABC0_0009);
        chk("R7 memory word0", mem[12'h050], 32'hABC0_0009);
        chk("R7 pc", pc_r, 32'h8000_1234);
        for (int k = 2; k < 16; k++) chk("R7 reg restored", rf[k], saved[k]);
        chk("R7 link restored", link_r, 32'h00F0_0000);
        chk("R7 free returned", free_r, 32'hABC3_0005);
        chk("R8 merged status", stat_r, 32'h0200_0001);
    endtask

    task automatic t_ret_full();
        req_next_pc = 32'h9000_0042;
        do_req(1'b0, 1'b0);
        chk("R3 second call free", free_r, 32'hABC0_0009);
        stat_r <= 32'h0100_0000;
        full_stat_restore = 1'b1;
        @(posedge clk); #5;
        do_req(1'b1, 1'b0);
        chk("R8 full status", stat_r, 32'h0200_0001);
        chk("R7 pc second", pc_r, 32'h9000_0042);
        chk("R7 free second", free_r, 32'hABC3_0005);
        full_stat_restore = 1'b0;
    endtask

    task automatic t_trap(input string tag, input logic ret, input logic [31:0] lk,
                          input logic [31:0] fr, input logic [31:0] lim, input logic [2:0] code);
        logic [31:0] a11_before;
        link_r <= lk; free_r <= fr; limit_r <= lim;
        @(posedge clk); #5;
        a11_before = rf[3];
        do_req(ret, 1'b0);
        @(posedge clk); #5;
        chk({tag, " code"}, {29'd0, last_code}, {29'd0, code});
        chk("R10 single pulse", 32'(trap_cnt), 32'd1);
        chk("R10 no access", 32'(log_n), 32'd0);
        chk("R10 no update", 32'(ctl_cnt), 32'd0);
        chk("R10 not busy", 32'(busy_cyc), 32'd0);
        chk("R10 link kept", link_r, lk);
        chk("R10 A11 kept", rf[3], a11_before);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = '0;
        link_r = '0; stat_r = '0; free_r = '0; limit_r = '0; pc_r = '0;
        prio_r = '0; ie_r = 1'b0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        #5;
        t_reset();
        rst_n = 1'b1;
        t_call_first();
        t_ret_merge();
        t_ret_full();
        t_trap("R5 zero free", 1'b0, 32'h00F0_0000, 32'hABC0_0000, 32'h0000_0077, 3'd1);
        t_trap("R5 zero and limit priority", 1'b0, 32'h00F0_0000, 32'h0000_0000, 32'h0000_0000, 3'd1);
        t_trap("R5 limit", 1'b0, 32'h00F0_0000, 32'h0000_0077, 32'h0000_0077, 3'd2);
        t_trap("R6 empty chain", 1'b1, 32'h00C0_0000, 32'hABC3_0005, 32'h0000_0077, 3'd3);
        t_trap("R6 wrong kind", 1'b1, 32'h0000_0005, 32'hABC3_0005, 32'h0000_0077, 3'd4);
        summary();
        $finish;
    end
endmodule